// File: doc/BRIEF.md
# Chainable Four-Channel Up-Counter Bank

The block holds four 16-bit up-counters. Each counter advances either on a tick from a shared free-running clock divider or, when chained, on the wrap of the counter one position below it. When a counter wraps past 0xFFFF it emits a one-cycle wrap pulse, which can clock an audio sample buffer, and an interrupt pulse if its interrupt bit is set. A counter that is not chained then restarts from its reload value. A chained counter starts again from zero.

Software reaches the counters through a small register port that takes 16-bit and 32-bit accesses. Each counter owns a 4-byte slot at byte offset 4*n. The low halfword of the slot reads as the live count and writes the reload value. The high halfword is the control word. Reads are combinational. Writes take effect at the next clock edge.

Top module: `timer_bank`

## Requirements
- R1: After reset every count, reload value and control word is zero, and `ovf_o` and `irq_o` are low.
- R2: A halfword write at slot offset 0 changes only the reload value. The live count is unchanged by it.
- R3: A control write that moves the enable bit (bit 0) from 0 to 1 loads the count from the reload value in effect after that write. A control write to a counter that is already enabled does not reload it.
- R4: An enabled counter that is not chained adds one per tick of its divider. The divider code sits in control bits [5:4]: code 0 is every cycle, code 1 every 64, code 2 every 256, code 3 every 1024 cycles. All counters use one shared divider that is zero at reset. From count c, a wrap happens after 0x10000-c ticks.
- R5: When a counter advances from 0xFFFF, `ovf_o` for that counter goes high for the following cycle. A counter that is not chained restarts from its reload value and keeps counting.
- R6: On a wrap, `irq_o` for that counter goes high together with `ovf_o` when interrupt-enable (control bit 2) is set, and stays low otherwise.
- R7: With the chain bit (control bit 1) set, counter n>0 ignores its divider and adds one on each wrap of counter n-1. If that add wraps counter n to zero, counter n wraps in the same cycle, so a whole chain can wrap at once. Counter 0 ignores the chain bit.
- R8: A disabled counter holds its count, and a chained counter holds its count between wraps of its predecessor.
- R9: A 32-bit access at slot offset 0 reads {control, count} and writes reload from bits [15:0] and control from bits [31:16]. A halfword access at offset 2 reads or writes the control word. Control bits 3 and 15:6 always read as zero.
- R10: Byte accesses (size code 0), size code 3 and misaligned accesses change nothing and read as zero.
- R11: When a reload write lands in the same cycle as a wrap of a counter that is not chained, the counter restarts from the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_sel | input | 1 | Register access valid this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| reg_addr | input | AW (4) | Byte address within the bank |
| reg_wdata | input | 32 | Write data; halfwords use bits [15:0] |
| reg_rdata | output | 32 | Read data, combinational |
| ovf_o | output | NUM_TMR (4) | One-cycle wrap pulse per counter |
| irq_o | output | NUM_TMR (4) | One-cycle interrupt pulse per counter |

## Verification
A reload write can land in the same cycle as the wrap that consumes the reload value. A control write can also land in the same cycle as the tick it would gate. The bench provokes the first collision directly. It sets counter 0 to wrap every cycle, writes a new reload value, and expects the count to restart from that new value on the next cycle. The random phase biases reload values toward 0xFFFx and divider codes toward 0 so that writes and wraps collide often. A cycle-level model in the bench judges each count and each pulse.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W   = 16;
    localparam int NUM_PSC = 4;
    localparam int DIV_W   = 10;
    localparam int PSC_SHIFT [NUM_PSC] = '{0, 6, 8, 10};

    typedef struct packed {
        logic [9:0] pad_hi;
        logic [1:0] psc;
        logic       pad_lo;
        logic       irq_en;
        logic       casc;
        logic       en;
    } tmr_ctl_t;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_t;

    function automatic tmr_ctl_t ctl_clean(input logic [CNT_W-1:0] w);
        tmr_ctl_t c;
        c        = tmr_ctl_t'(w);
        c.pad_hi = '0;
        c.pad_lo = 1'b0;
        return c;
    endfunction
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    output logic [NUM_PSC-1:0] tick_o
);
    logic [DIV_W-1:0] div_d, div_q;

    always_comb begin
        div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    for (genvar k = 0; k < NUM_PSC; k++) begin : g_tick
        if (PSC_SHIFT[k] == 0) begin : g_every
            assign tick_o[k] = 1'b1;
        end else begin : g_div
            assign tick_o[k] = &div_q[PSC_SHIFT[k]-1:0];
        end
    end

    // R4
    div_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o[NUM_PSC-1] |-> tick_o[1]);
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit
    import tmr_pkg::*;
#(
    parameter bit CAN_CASC = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_rel,
    input  logic               wr_ctl,
    input  logic [CNT_W-1:0]   rel_wdata,
    input  logic [CNT_W-1:0]   ctl_wdata,
    input  logic [NUM_PSC-1:0] tick_vec,
    input  logic               casc_in,
    output logic               ovf,
    output logic [CNT_W-1:0]   cnt_o,
    output tmr_ctl_t           ctl_o,
    output logic               ovf_o,
    output logic               irq_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] rel;
        tmr_ctl_t         ctl;
        logic             ovf;
        logic             irq;
    } unit_st_t;

    unit_st_t s_d, s_q;
    logic     chained;
    logic     inc;

    always_comb begin
        s_d     = s_q;
        s_d.ctl = wr_ctl ? ctl_clean(ctl_wdata) : s_q.ctl;
        s_d.rel = wr_rel ? rel_wdata : s_q.rel;
        chained = CAN_CASC && s_q.ctl.casc;
        inc     = s_q.ctl.en && (chained ? casc_in : tick_vec[s_q.ctl.psc]);
        ovf     = inc && (s_q.cnt == {CNT_W{1'b1}});
        if (s_d.ctl.en && !s_q.ctl.en) begin
            s_d.cnt = s_d.rel;
        end else if (inc) begin
            if (ovf) s_d.cnt = chained ? '0 : s_d.rel;
            else     s_d.cnt = s_q.cnt + 1'b1;
        end
        s_d.ovf = ovf;
        s_d.irq = ovf && s_q.ctl.irq_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;
    assign ctl_o = s_q.ctl;
    assign ovf_o = s_q.ovf;
    assign irq_o = s_q.irq;

    // R3
    load_on_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.ctl.en) |-> s_q.cnt == s_q.rel);

    // R8
    hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_q.ctl.en && !$past(s_q.ctl.en)) |-> $stable(s_q.cnt));

    if (CAN_CASC) begin : g_casc_chk
        // R7
        chain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (s_q.ctl.en && s_q.ctl.casc && !casc_in) |=> $stable(s_q.cnt));
    end
endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_pkg::*;
#(
    parameter int NUM_TMR = 4,
    parameter int AW      = 4
) (
    input  logic                            sel,
    input  logic                            we,
    input  logic [1:0]                      size,
    input  logic [AW-1:0]                   addr,
    input  logic [31:0]                     wdata,
    input  logic [NUM_TMR-1:0][CNT_W-1:0]   cnt_all,
    input  logic [NUM_TMR-1:0][CNT_W-1:0]   ctl_all,
    output logic [NUM_TMR-1:0]              wr_rel,
    output logic [NUM_TMR-1:0]              wr_ctl,
    output logic [CNT_W-1:0]                rel_wdata,
    output logic [CNT_W-1:0]                ctl_wdata,
    output logic [31:0]                     rdata
);
    localparam int SW = AW - 2;

    logic [SW-1:0] slot;
    logic          hit;

    always_comb begin
        wr_rel    = '0;
        wr_ctl    = '0;
        rel_wdata = wdata[CNT_W-1:0];
        ctl_wdata = wdata[CNT_W-1:0];
        rdata     = '0;
        slot      = addr[AW-1:2];
        hit       = sel && (int'(slot) < NUM_TMR);
        if (hit) begin
            case (acc_size_t'(size))
                SZ_HALF: if (!addr[0]) begin
                    if (we) begin
                        if (addr[1]) wr_ctl[slot] = 1'b1;
                        else         wr_rel[slot] = 1'b1;
                    end else begin
                        rdata = {16'h0, addr[1] ? ctl_all[slot] : cnt_all[slot]};
                    end
                end
                SZ_WORD: if (addr[1:0] == 2'b00) begin
                    if (we) begin
                        wr_rel[slot] = 1'b1;
                        wr_ctl[slot] = 1'b1;
                        ctl_wdata    = wdata[31:16];
                    end else begin
                        rdata = {ctl_all[slot], cnt_all[slot]};
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/timer_bank.sv
module timer_bank
    import tmr_pkg::*;
#(
    parameter  int NUM_TMR = 4,
    localparam int AW      = $clog2(NUM_TMR * 4)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_sel,
    input  logic               reg_we,
    input  logic [1:0]         reg_size,
    input  logic [AW-1:0]      reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    output logic [NUM_TMR-1:0] ovf_o,
    output logic [NUM_TMR-1:0] irq_o
);
    logic [NUM_PSC-1:0]            tick;
    logic [NUM_TMR-1:0]            wr_rel, wr_ctl;
    logic [CNT_W-1:0]              rel_wdata, ctl_wdata;
    logic [NUM_TMR-1:0][CNT_W-1:0] cnt_all, ctl_all;
    logic                          ovf_c [NUM_TMR];

    tmr_prescaler u_psc (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    tmr_regif #(.NUM_TMR(NUM_TMR), .AW(AW)) u_regif (
        .sel       (reg_sel),
        .we        (reg_we),
        .size      (reg_size),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .cnt_all   (cnt_all),
        .ctl_all   (ctl_all),
        .wr_rel    (wr_rel),
        .wr_ctl    (wr_ctl),
        .rel_wdata (rel_wdata),
        .ctl_wdata (ctl_wdata),
        .rdata     (reg_rdata)
    );

    for (genvar i = 0; i < NUM_TMR; i++) begin : g_unit
        logic     casc_src;
        tmr_ctl_t ctl_s;
        if (i == 0) begin : g_head
            assign casc_src = 1'b0;
        end else begin : g_link
            assign casc_src = ovf_c[i-1];
        end
        tmr_unit #(.CAN_CASC(i != 0)) u_tmr (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_rel    (wr_rel[i]),
            .wr_ctl    (wr_ctl[i]),
            .rel_wdata (rel_wdata),
            .ctl_wdata (ctl_wdata),
            .tick_vec  (tick),
            .casc_in   (casc_src),
            .ovf       (ovf_c[i]),
            .cnt_o     (cnt_all[i]),
            .ctl_o     (ctl_s),
            .ovf_o     (ovf_o[i]),
            .irq_o     (irq_o[i])
        );
        assign ctl_all[i] = ctl_s;
    end

    // R6
    irq_implies_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o & ~ovf_o) == '0);

    // R10
    byte_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_sel && !reg_we && reg_size == SZ_BYTE) |-> reg_rdata == 32'h0);
endmodule

// File: tb/timer_bank_tb.sv
module timer_bank_tb_top;
    localparam int N  = 4;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_sel = 1'b0, reg_we = 1'b0;
    logic [1:0]    reg_size = 2'd0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic [N-1:0]  ovf_o, irq_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    int unsigned m_cnt [N], m_rel [N], m_ctl [N];
    bit          m_ovf [N], m_irq [N];
    int unsigned m_div;

    always #10 clk = ~clk;

    timer_bank #(.NUM_TMR(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
        .reg_size(reg_size), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .ovf_o(ovf_o), .irq_o(irq_o)
    );

    task automatic chk(input bit ok, input string tag, input int unsigned act, input int unsigned exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    function automatic bit m_tick(input int unsigned code);
        int unsigned mask;
        case (code)
            0: mask = 0;
            1: mask = 63;
            2: mask = 255;
            default: mask = 1023;
        endcase
        return (m_div & mask) == mask;
    endfunction

    function automatic int unsigned m_read(input int unsigned size, input int unsigned addr);
        int unsigned s = addr >> 2;
        if (size == 1 && (addr & 1) == 0)
            return ((addr & 2) != 0) ? m_ctl[s] : m_cnt[s];
        if (size == 2 && (addr & 3) == 0)
            return (m_ctl[s] << 16) | m_cnt[s];
        return 0;
    endfunction

    task automatic m_step(input bit sel, input bit we, input int unsigned size,
                          input int unsigned addr, input int unsigned wd);
        int unsigned nrel [N], nctl [N], ncnt [N];
        bit prev = 1'b0;
        for (int i = 0; i < N; i++) begin
            nrel[i] = m_rel[i];
            nctl[i] = m_ctl[i];
        end
        if (sel && we) begin
            int unsigned s = addr >> 2;
            if (size == 1 && (addr & 1) == 0) begin
                if ((addr & 2) != 0) nctl[s] = wd & 32'h37;
                else                 nrel[s] = wd & 32'hFFFF;
            end else if (size == 2 && (addr & 3) == 0) begin
                nrel[s] = wd & 32'hFFFF;
                nctl[s] = (wd >> 16) & 32'h37;
            end
        end
        for (int i = 0; i < N; i++) begin
            bit en  = m_ctl[i][0];
            bit cas = (i > 0) && m_ctl[i][1];
            bit inc = en && (cas ? prev : m_tick((m_ctl[i] >> 4) & 3));
            bit o   = inc && (m_cnt[i] == 32'hFFFF);
            if (nctl[i][0] && !en)  ncnt[i] = nrel[i];
            else if (o)             ncnt[i] = cas ? 0 : nrel[i];
            else if (inc)           ncnt[i] = m_cnt[i] + 1;
            else                    ncnt[i] = m_cnt[i];
            m_ovf[i] = o;
            m_irq[i] = o && m_ctl[i][2];
            prev = o;
        end
        for (int i = 0; i < N; i++) begin
            m_cnt[i] = ncnt[i];
            m_rel[i] = nrel[i];
            m_ctl[i] = nctl[i];
        end
        m_div = (m_div + 1) & 1023;
    endtask

    task automatic cyc(input bit sel, input bit we, input int unsigned size,
                       input int unsigned addr, input int unsigned wd, input string tag);
        int unsigned ev = 0, ei = 0;
        reg_sel   = sel;
        reg_we    = we;
        reg_size  = size[1:0];
        reg_addr  = addr[AW-1:0];
        reg_wdata = wd;
        #1;
        if (sel && !we) chk(reg_rdata == m_read(size, addr), tag, reg_rdata, m_read(size, addr));
        m_step(sel, we, size, addr, wd);
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            ev |= int'(m_ovf[i]) << i;
            ei |= int'(m_irq[i]) << i;
        end
        chk(ovf_o == ev[N-1:0], "R5 R7 wrap pulses", ovf_o, ev);
        chk(irq_o == ei[N-1:0], "R6 interrupt pulses", irq_o, ei);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cyc(0, 0, 0, 0, 0, "idle");
    endtask

    task automatic rd(input int unsigned size, input int unsigned addr, input string tag);
        cyc(1, 0, size, addr, 0, tag);
    endtask

    task automatic wr(input int unsigned size, input int unsigned addr, input int unsigned wd, input string tag);
        cyc(1, 1, size, addr, wd, tag);
    endtask

    initial begin
        #(20 * 190000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < N; i++) begin
            m_cnt[i] = 0; m_rel[i] = 0; m_ctl[i] = 0; m_ovf[i] = 0; m_irq[i] = 0;
        end
        m_div = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk(ovf_o == '0 && irq_o == '0, "R1 outputs after reset", {ovf_o, irq_o}, 0);
        for (int s = 0; s < N; s++) rd(2, s * 4, "R1 R9 word read after reset");

        // R2: reload write leaves count alone
        wr(1, 0, 32'hFFFE, "R2 reload write");
        rd(1, 0, "R2 count unchanged by reload write");
        chk(reg_rdata == 0, "R2 count still zero", reg_rdata, 0);
        // R3: enabling loads, R6 with irq set
        wr(1, 2, 32'h0005, "R3 enable");
        rd(2, 0, "R3 R9 loaded count");
        idle(3);
        wr(1, 2, 32'h0005, "R3 rewrite while enabled");
        rd(1, 0, "R3 no reload on rewrite");
        rd(1, 2, "R9 control readback");
        wr(1, 2, 32'hFFCF, "R9 pad bits dropped");
        rd(1, 2, "R9 pad bits read zero");
        wr(1, 2, 0, "R8 disable");
        idle(3);
        rd(1, 0, "R8 held when disabled");

        // R7: whole chain wraps together
        for (int s = 1; s < N; s++) wr(2, s * 4, 32'h0007_FFFF, "R7 chain setup");
        wr(2, 0, 32'h0003_FFFD, "R7 head with chain bit ignored");
        idle(8);
        for (int s = 0; s < N; s++) rd(2, s * 4, "R7 R8 chain counts");
        for (int s = 0; s < N; s++) wr(2, s * 4, 0, "stop");

        // R11: reload write meets wrap
        wr(2, 0, 32'h0005_FFFF, "R11 wrap every cycle");
        idle(2);
        wr(1, 0, 32'h1234, "R11 reload during wrap");
        rd(1, 0, "R11 restarted from new reload");
        chk(reg_rdata[15:0] == 16'h1235, "R11 new reload in use", reg_rdata, 32'h1235);
        wr(2, 0, 0, "stop");

        // R10: byte, reserved and misaligned accesses
        for (int k = 0; k < 8; k++) begin
            wr(0, k, 32'hFFFF_FFFF, "R10 byte write ignored");
            wr(3, k & 12, 32'hFFFF_FFFF, "R10 reserved write ignored");
            wr(2, (k & 12) | 2, 32'h0001_0001, "R10 misaligned word ignored");
            rd(0, k, "R10 byte read zero");
            rd(1, k | 1, "R10 odd halfword read zero");
        end
        for (int s = 0; s < N; s++) rd(2, s * 4, "R10 state untouched");

        // R4: slow divider codes
        wr(2, 4, 32'h0015_FFFE, "R4 div64 setup");
        wr(2, 0, 32'h0035_FFFE, "R4 div1024 setup");
        for (int k = 0; k < 24; k++) begin
            idle(99);
            rd(2, 0, "R4 div1024 count");
            rd(2, 4, "R4 div64 count");
        end
        for (int s = 0; s < N; s++) wr(2, s * 4, 0, "stop");

        // random mix
        for (int k = 0; k < 6000; k++) begin
            int unsigned op   = $urandom % 8;
            int unsigned addr = $urandom % 16;
            int unsigned rel  = ($urandom % 3 != 0) ? (32'hFFF0 | ($urandom % 16)) : ($urandom % 65536);
            int unsigned ctl  = ($urandom % 65536) & ~32'h30;
            ctl |= (($urandom % 4 == 0) ? ($urandom % 4) : 0) << 4;
            case (op)
                0, 1: rd(1 + ($urandom % 2), addr & 14, "R9 random read");
                2:    rd($urandom % 4, addr, "R10 random any-size read");
                3:    wr(1, addr & 12, rel, "R2 random reload");
                4:    wr(1, (addr & 12) | 2, ctl, "R3 random control");
                5:    wr(2, addr & 12, (ctl << 16) | rel, "R9 random word write");
                6:    wr(0, addr, $urandom, "R10 random byte write");
                default: idle(1 + $urandom % 20);
            endcase
        end
        for (int s = 0; s < N; s++) rd(2, s * 4, "R5 final counts");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule